// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

A bank of 32 general-purpose pins behind a small memory-mapped register bus. Software drives output values and output enables, reads back synchronized pin levels, and picks a trigger type for each pin. The trigger can be a rising edge, a falling edge, a high level or a low level. Qualifying events are latched in a status register. The enabled part of that status is folded into one registered interrupt line for the whole bank.

Every register can be reached in three ways. A plain access replaces the whole register. A set access ORs in the bits written as one. A clear access removes the bits written as one. Because of the set and clear accesses, one pin can be changed without a read-modify-write. The status register is the exception: software can only clear it, and only the pins can set it. A pin can interrupt only when two gates are open. Its routing bit must be set for the status bit to latch, and its enable bit must be set for that status bit to reach the interrupt line.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads as zero, and the interrupt line, pin outputs and output enables are low.
- R2: The register index is in address bits [7:4]: 0 output data, 1 output enable, 2 input data, 3 interrupt routing, 4 interrupt enable, 5 trigger level select, 6 trigger polarity, 7 status. A plain write (bits [3:2]=0) replaces the register. A read at any of these addresses returns the register value on the cycle after the request. Writes with bits [3:2]=3 or with a nonzero bits [1:0] change nothing.
- R3: A write with bits [3:2]=1 ORs the written ones into the register, and a write with bits [3:2]=2 clears the bits written as one. All other bits keep their value.
- R4: The pin outputs and output enables equal the output data and output enable registers.
- R5: The input data register shows the pins through two synchronizer flops: a pin change is first visible on a read issued two cycles after it. Writes to the input data register have no effect.
- R6: With level bit 0, the pin triggers on an edge: polarity 1 means rising and polarity 0 means falling. Each qualifying transition sets the status bit once, and the bit stays set until cleared.
- R7: With level bit 1, the pin triggers on a level: polarity 1 means high and polarity 0 means low. The status bit is set again on every cycle the synchronized pin is at the active level, so a clear has no lasting effect while that level holds.
- R8: A status bit can be set only while that pin's routing bit is one.
- R9: Status bits are cleared only by a clear-type write. Plain and set-type writes to the status register leave it unchanged.
- R10: The interrupt line is the OR over all pins of (status AND enable), registered. It rises one cycle after the first enabled status bit is set and falls one cycle after the last one is cleared or disabled.
- R11: When a pin event and a clear-type write to that status bit fall in the same cycle, the status bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus request valid this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address: index [7:4], access type [3:2] |
| bus_wdata_i | input | N_PINS | Write data |
| bus_rdata_o | output | N_PINS | Read data, valid the cycle after a read request |
| pins_i | input | N_PINS | Asynchronous pin levels |
| gpio_o | output | N_PINS | Output data to pads |
| gpio_oe_o | output | N_PINS | Output enables to pads |
| irq_o | output | 1 | Combined bank interrupt |

## Verification
A software acknowledge of a status bit can land in the same cycle as a fresh hardware event on that pin. The two collide in the status register's next-state logic. The bench provokes this collision in two ways. First, it lets a rising edge reach the synchronizer output and issues a clear-type write so that the write is sampled on the very edge where the event is detected. Second, it clears a level-triggered pin while the pin is held at its active level. In both cases the status is read back on the next cycle and must still show the bit set. A separate step confirms that the same clear, with no event present, really does remove the bit.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_NONE  = 2'd3
  } reg_op_e;

  localparam int unsigned N_REGS    = 8;
  localparam int unsigned IDX_DOUT  = 0;
  localparam int unsigned IDX_OE    = 1;
  localparam int unsigned IDX_DIN   = 2;
  localparam int unsigned IDX_ROUTE = 3;
  localparam int unsigned IDX_IEN   = 4;
  localparam int unsigned IDX_LVL   = 5;
  localparam int unsigned IDX_POL   = 6;
  localparam int unsigned IDX_STAT  = 7;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W        = 32,
  parameter bit          CLR_ONLY = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  reg_op_e      op_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] hw_set_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] val_q, val_d;

  always_comb begin
    val_d = val_q;
    if (we_i) begin
      unique case (op_i)
        OP_WRITE: if (!CLR_ONLY) val_d = wdata_i;
        OP_SET:   if (!CLR_ONLY) val_d = val_q | wdata_i;
        OP_CLR:   val_d = val_q & ~wdata_i;
        default:  val_d = val_q;
      endcase
    end
    // hardware set wins over a same-cycle clear
    val_d = val_d | hw_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= '0;
    else         val_q <= val_d;
  end

  assign q_o = val_q;
endmodule

// File: rtl/gpio_event_det.sv
module gpio_event_det #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] gate_i,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] prev_q, trig;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= din_i;
  end

  for (genvar p = 0; p < W; p++) begin : g_pin
    assign trig[p] = lvl_i[p] ? ~(din_i[p] ^ pol_i[p])
                   : (pol_i[p] ? (din_i[p] & ~prev_q[p])
                               : (~din_i[p] & prev_q[p]));
  end

  assign hit_o = trig & gate_i;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [N_PINS-1:0] bus_wdata_i,
  output logic [N_PINS-1:0] bus_rdata_o,
  input  logic [N_PINS-1:0] pins_i,
  output logic [N_PINS-1:0] gpio_o,
  output logic [N_PINS-1:0] gpio_oe_o,
  output logic              irq_o
);
  localparam int unsigned IDX_W = ADDR_W - 4;
  localparam int unsigned SEL_W = $clog2(N_REGS);

  logic [IDX_W-1:0]  idx;
  logic [SEL_W-1:0]  sel;
  logic              aligned, mapped, wr_ok, rd_ok;
  reg_op_e           op;
  logic [N_PINS-1:0] regs [N_REGS];
  logic [N_PINS-1:0] din_q, stat_set;
  logic [N_PINS-1:0] stat_q, ien_q, route_q, lvl_q, pol_q;
  logic [N_PINS-1:0] rdata_q;
  logic              irq_q;

  assign idx     = bus_addr_i[ADDR_W-1:4];
  assign sel     = idx[SEL_W-1:0];
  assign op      = reg_op_e'(bus_addr_i[3:2]);
  assign aligned = (bus_addr_i[1:0] == 2'b00);
  assign mapped  = (idx[IDX_W-1:SEL_W] == '0);
  assign wr_ok   = bus_valid_i &  bus_write_i & aligned & mapped;
  assign rd_ok   = bus_valid_i & ~bus_write_i & aligned & mapped;

  gpio_sync2 #(.W(N_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .q_o   (din_q)
  );

  for (genvar r = 0; r < N_REGS; r++) begin : g_reg
    if (r == IDX_DIN) begin : g_ro
      assign regs[r] = din_q;
    end else begin : g_rw
      localparam bit IS_STAT = (r == IDX_STAT);
      gpio_alias_reg #(.W(N_PINS), .CLR_ONLY(IS_STAT)) u_reg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (wr_ok && (sel == SEL_W'(r))),
        .op_i    (op),
        .wdata_i (bus_wdata_i),
        .hw_set_i(IS_STAT ? stat_set : '0),
        .q_o     (regs[r])
      );
    end
  end

  assign stat_q  = regs[IDX_STAT];
  assign ien_q   = regs[IDX_IEN];
  assign route_q = regs[IDX_ROUTE];
  assign lvl_q   = regs[IDX_LVL];
  assign pol_q   = regs[IDX_POL];

  gpio_event_det #(.W(N_PINS)) u_evt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .din_i (din_q),
    .lvl_i (lvl_q),
    .pol_i (pol_q),
    .gate_i(route_q),
    .hit_o (stat_set)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (rd_ok) rdata_q <= regs[sel];
      irq_q <= |(stat_q & ien_q);
    end
  end

  assign bus_rdata_o = rdata_q;
  assign gpio_o      = regs[IDX_DOUT];
  assign gpio_oe_o   = regs[IDX_OE];
  assign irq_o       = irq_q;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int unsigned N_PINS = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_valid_i,
  input logic              bus_write_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [N_PINS-1:0] bus_rdata_o,
  input logic [N_PINS-1:0] din_q,
  input logic [N_PINS-1:0] stat_q,
  input logic [N_PINS-1:0] ien_q,
  input logic [N_PINS-1:0] route_q,
  input logic [N_PINS-1:0] lvl_q,
  input logic [N_PINS-1:0] pol_q,
  input logic              irq_o
);
  localparam logic [ADDR_W-1:0] STAT_CLR_ADDR = ADDR_W'(8'h78);

  logic clr_hit;
  assign clr_hit = bus_valid_i && bus_write_i && (bus_addr_i == STAT_CLR_ADDR);

  a_r10_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(stat_q & ien_q)) |=> irq_o);

  a_r10_irq_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(stat_q & ien_q)) |=> !irq_o);

  a_r9_clear_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(stat_q) & ~stat_q) == '0) || $past(clr_hit)));

  a_r7_level_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(lvl_q & ~(din_q ^ pol_q) & route_q) & ~stat_q) == '0));

  a_r8_route_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(~route_q) & stat_q & ~$past(stat_q)) == '0));

  a_r2_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_valid_i && !bus_write_i) |=> $stable(bus_rdata_o));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_valid_i(bus_valid_i),
  .bus_write_i(bus_write_i),
  .bus_addr_i (bus_addr_i),
  .bus_rdata_o(bus_rdata_o),
  .din_q      (din_q),
  .stat_q     (stat_q),
  .ien_q      (ien_q),
  .route_q    (route_q),
  .lvl_q      (lvl_q),
  .pol_q      (pol_q),
  .irq_o      (irq_o)
);

// File: tb/gpio_irq_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb_top;
  localparam logic [7:0] A_DOUT = 8'h00, A_OE = 8'h10, A_DIN = 8'h20, A_ROUTE = 8'h30;
  localparam logic [7:0] A_IEN = 8'h40, A_LVL = 8'h50, A_POL = 8'h60, A_STAT = 8'h70;
  localparam logic [7:0] K_SET = 8'h04, K_CLR = 8'h08, K_NONE = 8'h0C;

  typedef struct packed {
    logic [7:0]  waddr;
    logic [31:0] wdata;
    logic [7:0]  raddr;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int N_VEC = 11;
  localparam vec_t TBL [N_VEC] = '{
    '{8'h00, 32'hA5A5_0F0F, 8'h00, 32'hA5A5_0F0F, 4'd2},  // R2 plain
    '{8'h04, 32'h0000_F000, 8'h00, 32'hA5A5_FF0F, 4'd3},  // R3 set
    '{8'h08, 32'hA500_000F, 8'h00, 32'h00A5_FF00, 4'd3},  // R3 clear
    '{8'h10, 32'hFFFF_0000, 8'h10, 32'hFFFF_0000, 4'd2},  // R2
    '{8'h18, 32'h0F00_0000, 8'h14, 32'hF0FF_0000, 4'd3},  // R3 clear, read via set alias
    '{8'h1C, 32'h1234_5678, 8'h18, 32'hF0FF_0000, 4'd2},  // R2 type 3 ignored
    '{8'h11, 32'h0000_0000, 8'h10, 32'hF0FF_0000, 4'd2},  // R2 misaligned ignored
    '{8'h34, 32'h0000_0081, 8'h30, 32'h0000_0081, 4'd3},  // R3
    '{8'h40, 32'h0000_0003, 8'h40, 32'h0000_0003, 4'd2},  // R2
    '{8'h54, 32'h0000_0004, 8'h50, 32'h0000_0004, 4'd3},  // R3
    '{8'h60, 32'h0000_000F, 8'h60, 32'h0000_000F, 4'd2}   // R2
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, pins = '0;
  logic [31:0] rdata, gpio, gpio_oe;
  logic        irq;
  int          n_checks = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(write),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pins_i(pins), .gpio_o(gpio), .gpio_oe_o(gpio_oe), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // tasks are entered and left at a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    valid = 1'b1; write = 1'b0; addr = a;
    @(negedge clk);
    valid = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd(8'(i * 16), v);
      check($sformatf("R1 reg %0d after reset", i), v, 32'h0);
    end
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 gpio_o after reset", gpio, 32'h0);

    // table-driven register accesses
    for (int i = 0; i < N_VEC; i++) begin
      wr(TBL[i].waddr, TBL[i].wdata);
      rd(TBL[i].raddr, v);
      check($sformatf("R%0d vector %0d", TBL[i].req, i), v, TBL[i].exp);
    end
    check("R4 gpio_o", gpio, 32'h00A5_FF00);
    check("R4 gpio_oe_o", gpio_oe, 32'hF0FF_0000);

    // R6 rising edge, R10 timing
    wr(A_LVL, 0); wr(A_POL, 32'h1); wr(A_ROUTE, 32'h1); wr(A_IEN, 32'h1);
    wr(A_STAT | K_CLR, '1);
    pins = 32'h1;
    idle(3);
    check("R10 irq low while status just set", {31'b0, irq}, 32'h0);
    idle(1);
    check("R10 irq high one cycle after status", {31'b0, irq}, 32'h1);
    rd(A_STAT, v); check("R6 rising edge sets status", v, 32'h1);
    wr(A_STAT | K_CLR, 32'h1);
    idle(3);
    rd(A_STAT, v); check("R6 edge sets status only once", v, 32'h0);
    check("R10 irq falls after clear", {31'b0, irq}, 32'h0);

    // R6 falling edge
    wr(A_POL, 0);
    pins = 32'h0;
    idle(4);
    rd(A_STAT, v); check("R6 falling edge sets status", v, 32'h1);

    // R9 plain/set writes cannot touch status
    wr(A_STAT, 32'h0);
    wr(A_STAT | K_SET, 32'h2);
    rd(A_STAT, v); check("R9 status unchanged by plain/set writes", v, 32'h1);
    wr(A_STAT | K_CLR, '1);
    rd(A_STAT, v); check("R9 clear-type write clears status", v, 32'h0);

    // R7 level triggers
    wr(A_LVL, 32'h1);               // low level, pin is low
    idle(4);
    wr(A_STAT | K_CLR, 32'h1);
    rd(A_STAT, v); check("R7 low level re-sets after clear", v, 32'h1);
    wr(A_POL, 32'h1);               // high level, pin low
    idle(2);
    wr(A_STAT | K_CLR, 32'h1);
    rd(A_STAT, v); check("R7 inactive level stays clear", v, 32'h0);
    pins = 32'h1;
    idle(4);
    wr(A_STAT | K_CLR, 32'h1);
    rd(A_STAT, v); check("R7 high level re-sets after clear", v, 32'h1);
    pins = 32'h0;
    idle(4);
    wr(A_STAT | K_CLR, 32'h1);
    rd(A_STAT, v); check("R7 released level clears", v, 32'h0);
    wr(A_LVL, 0);

    // R8 routing gate, R10 enable gate
    wr(A_POL, 32'h10); wr(A_ROUTE, 0); wr(A_IEN, 0);
    wr(A_STAT | K_CLR, '1);
    pins = 32'h10;
    idle(4);
    rd(A_STAT, v); check("R8 unrouted edge not latched", v, 32'h0);
    pins = 32'h0;
    idle(4);
    wr(A_ROUTE, 32'h10);
    pins = 32'h10;
    idle(4);
    rd(A_STAT, v); check("R8 routed edge latched", v, 32'h10);
    check("R10 irq held off by enable", {31'b0, irq}, 32'h0);
    wr(A_IEN | K_SET, 32'h10);
    check("R10 irq one cycle after enable", {31'b0, irq}, 32'h0);
    idle(1);
    check("R10 irq after enable", {31'b0, irq}, 32'h1);

    // R11 event and clear in the same cycle
    pins = 32'h0;
    idle(4);
    wr(A_STAT | K_CLR, '1);
    rd(A_STAT, v); check("R11 precondition status clear", v, 32'h0);
    pins = 32'h10;
    idle(2);
    wr(A_STAT | K_CLR, 32'h10);
    rd(A_STAT, v); check("R11 same-cycle event wins over clear", v, 32'h10);

    // R5 synchronizer latency and read-only input
    pins = 32'hDEAD_BEF0;
    rd(A_DIN, v);
    rd(A_DIN, v); check("R5 not visible after one cycle", v, 32'h0000_0010);
    rd(A_DIN, v); check("R5 visible after two flops", v, 32'hDEAD_BEF0);
    wr(A_DIN, 32'h0);
    wr(A_DIN | K_CLR, '1);
    rd(A_DIN, v); check("R5 writes to input data ignored", v, 32'hDEAD_BEF0);

    // R1 reset mid-run
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    rd(A_ROUTE, v); check("R1 routing cleared by reset", v, 32'h0);
    rd(A_IEN, v);   check("R1 enable cleared by reset", v, 32'h0);
    rd(A_STAT, v);  check("R1 status cleared by reset", v, 32'h0);
    check("R1 irq low after reset", {31'b0, irq}, 32'h0);
    check("R1 gpio_oe_o low after reset", gpio_oe, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule